// File: doc/BRIEF.md
# Count/Compare Timer with Routed Interrupt

This block is a timer of the kind found beside a processor core. A 32-bit count register advances on its own. A 32-bit compare register holds a target value. Software may overwrite either register at any time. When the count equals the compare value while counting is enabled, a level interrupt is latched. It stays up until software writes the compare register, which is the acknowledge.

A freeze input stops the count and blocks new interrupts. A 3-bit routing field picks which of eight interrupt outputs carries the latched level. A separate pending flag reports the interrupt to a cause-style status bit, but only when the revision-2 feature input is set.

A prescale parameter sets how many clock cycles make up one count step; the default is one step per cycle.

Top module: `cc_timer`

## Requirements
- R1: After reset the count reads 1, the compare value is 0, every interrupt output is low and the pending flag is 0.
- R2: While `freeze` is low and no count write occurs, the count rises by exactly one every PRESCALE clock cycles.
- R3: While `freeze` is high, the count holds its value and no interrupt is latched, even if the count equals the compare value.
- R4: A count write loads `cnt_wr_data` at the next clock edge, takes priority over an increment, works while frozen, and match detection continues from the loaded value.
- R5: When `freeze` is low and the count equals the compare value, the interrupt level is latched at the next clock edge.
- R6: The latched level stays asserted after the count moves past the compare value, until a compare write.
- R7: A compare write loads the compare value and clears the level and the pending flag at the next edge. It wins over a match in the same cycle.
- R8: With `rev2_en` high, `pend_flag` is set with the level and cleared by a compare write. With `rev2_en` low, `pend_flag` is 0.
- R9: `irq_out` is zero when no interrupt is latched. Otherwise exactly bit `irq_out[line_sel]` is set. A change of `line_sel` moves the interrupt in the same cycle.
- R10: With PRESCALE = N, a count write restarts the step phase, so the first increment after the write comes N cycles after the load.
- R11: The count wraps from 0xFFFFFFFF to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freeze | input | 1 | Stops counting and blocks new interrupts |
| cnt_wr_en | input | 1 | Count register write strobe |
| cnt_wr_data | input | 32 | Value for count write |
| cmp_wr_en | input | 1 | Compare register write strobe (acknowledge) |
| cmp_wr_data | input | 32 | Value for compare write |
| rev2_en | input | 1 | Enables the pending flag |
| line_sel | input | 3 | Interrupt output index |
| cnt_value | output | 32 | Current count |
| pend_flag | output | 1 | Pending status flag |
| irq_out | output | 8 | One-hot interrupt outputs |

## Verification
The main path is tried in several ways:
- A match reached by counting across the wrap point, which ties the reset compare value of 0 to the wrap behaviour.
- A match created by loading the count to the compare value while frozen and then releasing the freeze, which separates the effect of freezing from the effect of loading.
- A compare write in the same cycle as a match, which shows whether the acknowledge has priority.
- A match with the feature flag off, which separates the interrupt level from the pending flag.

A second instance with a prescale of three shows whether a count write restarts the step phase. Moving the routing field while the interrupt is latched, and again while it is idle, shows that routing is purely combinational.

// File: rtl/cc_timer_pkg.sv
`timescale 1ns/1ps
package cc_timer_pkg;
  localparam int CC_CNT_W_DEF   = 32;
  localparam int CC_LINES_DEF   = 8;
  localparam int CC_RESET_COUNT = 1;

  typedef struct packed {
    logic lvl;
    logic pend;
  } cc_irq_state_t;
endpackage

// File: rtl/cc_prescale.sv
`timescale 1ns/1ps
module cc_prescale #(
  parameter int DIV = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PH_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);

  logic [PH_W-1:0] phase_q;

  function automatic logic at_last(input logic [PH_W-1:0] ph);
    return ph == LAST;
  endfunction

  assign tick = run && at_last(phase_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase_q <= '0;
    else if (restart || tick)
      phase_q <= '0;
    else if (run)
      phase_q <= phase_q + 1'b1;
  end
endmodule

// File: rtl/cc_count_reg.sv
`timescale 1ns/1ps
module cc_count_reg #(
  parameter int CNT_W = 32,
  parameter int INIT  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] INIT_V = CNT_W'(INIT);

  logic [CNT_W-1:0] count_q;

  // modulo 2^CNT_W step
  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c);
    return c + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      count_q <= INIT_V;
    else if (wr_en)
      count_q <= wr_data;
    else if (tick)
      count_q <= next_count(count_q);
  end

  assign count = count_q;
endmodule

// File: rtl/cc_match_irq.sv
`timescale 1ns/1ps
module cc_match_irq
  import cc_timer_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int LINES = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] count,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             rev2_en,
  input  logic [SEL_W-1:0] line_sel,
  output logic [CNT_W-1:0] cmp_val,
  output logic             match_evt,
  output logic             irq_lvl,
  output logic             pend,
  output logic [LINES-1:0] irq_vec
);
  logic [CNT_W-1:0] cmp_q;
  cc_irq_state_t    st_q, st_d;

  function automatic logic is_hit(input logic [CNT_W-1:0] c,
                                  input logic [CNT_W-1:0] k);
    return c == k;
  endfunction

  assign match_evt = run && is_hit(count, cmp_q);

  always_comb begin
    st_d = st_q;
    if (cmp_wr_en) begin
      st_d.lvl  = 1'b0;
      st_d.pend = 1'b0;
    end else if (match_evt) begin
      st_d.lvl  = 1'b1;
      st_d.pend = 1'b1;
    end
    if (!rev2_en)
      st_d.pend = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      st_q  <= '0;
    end else begin
      if (cmp_wr_en)
        cmp_q <= cmp_wr_data;
      st_q <= st_d;
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_route
    assign irq_vec[i] = st_q.lvl && (line_sel == SEL_W'(i));
  end

  assign cmp_val = cmp_q;
  assign irq_lvl = st_q.lvl;
  assign pend    = st_q.pend;
endmodule

// File: rtl/cc_timer.sv
`timescale 1ns/1ps
module cc_timer
  import cc_timer_pkg::*;
#(
  parameter int CNT_W    = CC_CNT_W_DEF,
  parameter int LINES    = CC_LINES_DEF,
  parameter int PRESCALE = 1,
  localparam int SEL_W   = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             freeze,
  input  logic             cnt_wr_en,
  input  logic [CNT_W-1:0] cnt_wr_data,
  input  logic             cmp_wr_en,
  input  logic [CNT_W-1:0] cmp_wr_data,
  input  logic             rev2_en,
  input  logic [SEL_W-1:0] line_sel,
  output logic [CNT_W-1:0] cnt_value,
  output logic             pend_flag,
  output logic [LINES-1:0] irq_out
);
  logic             run;
  logic             tick;
  logic [CNT_W-1:0] cmp_val;
  logic             match_evt;
  logic             irq_lvl;

  assign run = !freeze;

  cc_prescale #(.DIV(PRESCALE)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .restart (cnt_wr_en),
    .tick    (tick)
  );

  cc_count_reg #(.CNT_W(CNT_W), .INIT(CC_RESET_COUNT)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cnt_wr_en),
    .wr_data (cnt_wr_data),
    .tick    (tick),
    .count   (cnt_value)
  );

  cc_match_irq #(.CNT_W(CNT_W), .LINES(LINES), .SEL_W(SEL_W)) u_irq (
    .clk         (clk),
    .rst_n       (rst_n),
    .run         (run),
    .count       (cnt_value),
    .cmp_wr_en   (cmp_wr_en),
    .cmp_wr_data (cmp_wr_data),
    .rev2_en     (rev2_en),
    .line_sel    (line_sel),
    .cmp_val     (cmp_val),
    .match_evt   (match_evt),
    .irq_lvl     (irq_lvl),
    .pend        (pend_flag),
    .irq_vec     (irq_out)
  );
endmodule

// File: rtl/cc_timer_chk.sv
`timescale 1ns/1ps
module cc_timer_chk #(
  parameter int CNT_W = 32,
  parameter int LINES = 8,
  localparam int SEL_W = $clog2(LINES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             freeze,
  input logic             cnt_wr_en,
  input logic [CNT_W-1:0] cnt_wr_data,
  input logic             cmp_wr_en,
  input logic             rev2_en,
  input logic [SEL_W-1:0] line_sel,
  input logic [CNT_W-1:0] cnt_value,
  input logic             pend_flag,
  input logic [LINES-1:0] irq_out,
  input logic             tick,
  input logic [CNT_W-1:0] cmp_val,
  input logic             irq_lvl,
  input logic             match_evt
);
  // R2
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cnt_wr_en) |=> cnt_value == $past(cnt_value) + 1'b1);

  // R3
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !cnt_wr_en) |=> $stable(cnt_value));

  // R3
  freeze_noirq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !irq_lvl) |=> !irq_lvl);

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr_en |=> cnt_value == $past(cnt_wr_data));

  // R5
  match_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!freeze && cnt_value == cmp_val) |-> match_evt);

  // R5
  match_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_evt && !cmp_wr_en) |=> irq_lvl);

  // R6
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lvl && !cmp_wr_en) |=> irq_lvl);

  // R7
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_en |=> (irq_out == '0 && !pend_flag));

  // R8
  pend_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rev2_en |=> !pend_flag);

  // R9
  route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_out) && (irq_lvl == (irq_out != '0)));

  // R9
  route_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lvl |-> irq_out[line_sel]);
endmodule

bind cc_timer cc_timer_chk #(.CNT_W(CNT_W), .LINES(LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .freeze      (freeze),
  .cnt_wr_en   (cnt_wr_en),
  .cnt_wr_data (cnt_wr_data),
  .cmp_wr_en   (cmp_wr_en),
  .rev2_en     (rev2_en),
  .line_sel    (line_sel),
  .cnt_value   (cnt_value),
  .pend_flag   (pend_flag),
  .irq_out     (irq_out),
  .tick        (tick),
  .cmp_val     (cmp_val),
  .irq_lvl     (irq_lvl),
  .match_evt   (match_evt)
);

// File: tb/sim_cc_timer.sv
`timescale 1ns/1ps
module sim_cc_timer;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        freeze, cnt_wr_en, cmp_wr_en, rev2_en;
  logic [31:0] cnt_wr_data, cmp_wr_data;
  logic [2:0]  line_sel;
  logic [31:0] cnt0, cnt1;
  logic [7:0]  irq0, irq1;
  logic        pend0, pend1;

  always #2.5 clk = ~clk;

  cc_timer u0 (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .cnt_wr_en(cnt_wr_en),
    .cnt_wr_data(cnt_wr_data), .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .rev2_en(rev2_en), .line_sel(line_sel), .cnt_value(cnt0),
    .pend_flag(pend0), .irq_out(irq0)
  );

  cc_timer #(.PRESCALE(3)) u1 (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .cnt_wr_en(cnt_wr_en),
    .cnt_wr_data(cnt_wr_data), .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .rev2_en(rev2_en), .line_sel(line_sel), .cnt_value(cnt1),
    .pend_flag(pend1), .irq_out(irq1)
  );

  // kind: 0 = u0 count, 1 = u0 irq vector, 2 = u0 pending, 3 = u1 count
  typedef struct {
    int          at;
    int          kind;
    logic [31:0] val;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_at(input int d, input int kind, input logic [31:0] v,
                           input string tag);
    exp_t e;
    int   pos;
    e.at = cyc + d; e.kind = kind; e.val = v; e.tag = tag;
    pos = sb.size();
    for (int i = 0; i < sb.size(); i++) begin
      if (sb[i].at > e.at) begin pos = i; break; end
    end
    sb.insert(pos, e);
  endtask

  function automatic logic [31:0] observe(input int kind);
    case (kind)
      0:       return cnt0;
      1:       return {24'h0, irq0};
      2:       return {31'h0, pend0};
      default: return cnt1;
    endcase
  endfunction

  // monitor
  always @(negedge clk) begin
    exp_t        e;
    logic [31:0] act;
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e   = sb.pop_front();
      act = observe(e.kind);
      n_chk++;
      if (e.at != cyc || act !== e.val) begin
        n_fail++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                 e.tag, e.kind, cyc, act, e.val);
      end
    end
  end

  task automatic nstep(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; freeze = 1'b1; cnt_wr_en = 1'b0; cmp_wr_en = 1'b0;
    cnt_wr_data = '0; cmp_wr_data = '0; rev2_en = 1'b1; line_sel = 3'd0;
    nstep(3);
    rst_n = 1'b1;
    // R1 reset values (frozen, so count stays 1)
    expect_at(1, 0, 32'd1, "R1");
    expect_at(1, 1, 32'h0, "R1");
    expect_at(1, 2, 32'h0, "R1");
    expect_at(2, 0, 32'd1, "R1");
    nstep(3);

    // A: count across wrap into reset compare value 0
    cnt_wr_en = 1'b1; cnt_wr_data = 32'hFFFF_FFFE; freeze = 1'b0;
    expect_at(2, 0, 32'hFFFF_FFFF, "R2");
    expect_at(3, 0, 32'h0, "R11");
    expect_at(3, 1, 32'h0, "R5");
    expect_at(4, 1, 32'h01, "R5");
    expect_at(4, 2, 32'h1, "R8");
    expect_at(6, 1, 32'h01, "R6");
    expect_at(6, 0, 32'd3, "R6");
    nstep(1);
    cnt_wr_en = 1'b0;
    nstep(6);
    line_sel = 3'd5;                     // R9 move while latched
    expect_at(1, 1, 32'h20, "R9");
    expect_at(1, 2, 32'h1, "R8");
    nstep(2);
    cmp_wr_en = 1'b1; cmp_wr_data = 32'h100;
    expect_at(1, 1, 32'h0, "R7");
    expect_at(1, 2, 32'h0, "R7");
    nstep(1);
    cmp_wr_en = 1'b0;
    nstep(1);

    // B: frozen load equal to compare, then release
    freeze = 1'b1; cnt_wr_en = 1'b1; cnt_wr_data = 32'd50;
    cmp_wr_en = 1'b1; cmp_wr_data = 32'd52;
    expect_at(1, 0, 32'd50, "R4");
    expect_at(3, 0, 32'd50, "R3");
    nstep(1);
    cnt_wr_en = 1'b0; cmp_wr_en = 1'b0;
    nstep(2);
    cnt_wr_en = 1'b1; cnt_wr_data = 32'd52;
    expect_at(1, 0, 32'd52, "R4");
    expect_at(3, 0, 32'd52, "R3");
    expect_at(3, 1, 32'h0, "R3");
    nstep(1);
    cnt_wr_en = 1'b0;
    nstep(2);
    freeze = 1'b0;
    expect_at(1, 1, 32'h20, "R5");
    expect_at(1, 0, 32'd53, "R2");
    nstep(2);
    cmp_wr_en = 1'b1; cmp_wr_data = 32'h1000;
    expect_at(1, 1, 32'h0, "R7");
    nstep(1);
    cmp_wr_en = 1'b0;
    nstep(1);

    // C: compare write in the same cycle as a match
    freeze = 1'b1; cnt_wr_en = 1'b1; cnt_wr_data = 32'd300;
    cmp_wr_en = 1'b1; cmp_wr_data = 32'd300;
    nstep(1);
    cnt_wr_en = 1'b0; freeze = 1'b0; cmp_wr_data = 32'h5000;
    expect_at(1, 1, 32'h0, "R7");
    expect_at(1, 0, 32'd301, "R2");
    expect_at(3, 1, 32'h0, "R7");
    nstep(1);
    cmp_wr_en = 1'b0;
    nstep(1);

    // D: match with the feature flag off
    rev2_en = 1'b0; freeze = 1'b1; cnt_wr_en = 1'b1; cnt_wr_data = 32'd400;
    cmp_wr_en = 1'b1; cmp_wr_data = 32'd402;
    nstep(1);
    cnt_wr_en = 1'b0; cmp_wr_en = 1'b0; freeze = 1'b0;
    expect_at(2, 1, 32'h0, "R5");
    expect_at(3, 1, 32'h20, "R5");
    expect_at(3, 2, 32'h0, "R8");
    nstep(4);
    cmp_wr_en = 1'b1; cmp_wr_data = 32'h6000;
    expect_at(1, 1, 32'h0, "R7");
    nstep(1);
    cmp_wr_en = 1'b0; rev2_en = 1'b1; line_sel = 3'd2;
    expect_at(1, 1, 32'h0, "R9");
    expect_at(1, 2, 32'h0, "R8");
    nstep(1);

    // E: prescaler phase restart on count write
    cnt_wr_en = 1'b1; cnt_wr_data = 32'd1000;
    expect_at(1, 3, 32'd1000, "R10");
    expect_at(3, 3, 32'd1000, "R10");
    expect_at(4, 3, 32'd1001, "R10");
    expect_at(7, 3, 32'd1002, "R10");
    expect_at(4, 0, 32'd1003, "R2");
    nstep(1);
    cnt_wr_en = 1'b0;
    nstep(10);

    if (sb.size() != 0) begin
      n_chk++;
      n_fail++;
      $display("FAIL scoreboard: actual=%0d left expected=0", sb.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule